// File: doc/BRIEF.md
# Low Transition ASCII Codec

This block sits between a host and a serial transmitter or receiver, and its purpose is to cut the number of edges on the line. When a frame starts and ends with a 0 bit, each level change on the wire costs pad power. The encoder path takes a host byte and replaces eight frequent lowercase letters with marker codes. Each marker code has bit 7 set, which plain 7-bit ASCII never uses, and is a run of ones followed by a run of zeros, so a framed marker code toggles the line only twice. Every other byte leaves the encoder unchanged. The decoder path sits on the receive side and reverses the substitution. A separate combinational counter reports how many level changes a given byte would cause on the line once it is framed.

Both paths are streams with valid/ready handshaking and one register stage each. A byte moves across an interface on a rising clock edge where valid and ready are both high. An output that is valid while its ready is low keeps the same byte until it is taken. The input of a path is ready whenever its output register is empty or is being drained in the same cycle, so a path with a consumer that never stalls accepts one byte on every cycle. The encoder and decoder paths share only the clock and reset.

Top module: `lt_ascii_codec`

## Requirements
- R1: While rst_n is low, and after reset until a byte is accepted, enc_out_valid and dec_out_valid are 0 and both input ready outputs are 1.
- R2: The encoder replaces each letter with its code. The letters and codes are, in frequency order: e (0x65) gives 0xFE, t (0x74) gives 0xFC, a (0x61) gives 0xF8, o (0x6F) gives 0xF0, i (0x69) gives 0xE0, n (0x6E) gives 0xC0, s (0x73) gives 0x80 and r (0x72) gives 0xFF.
- R3: The encoder sends every byte that is not one of the eight letters of R2 through unchanged. This includes bytes that have bit 7 set.
- R4: The decoder turns each of the eight codes of R2 back into its letter.
- R5: The decoder sends every byte that is not one of the eight codes through unchanged, whatever the value of bit 7.
- R6: A byte accepted on one rising edge is presented, with its output valid high, directly after that edge. This is one cycle of latency.
- R7: While an output is valid and its ready is low, on the following cycle the output is still valid and the data has not changed. No byte is dropped and no byte is duplicated.
- R8: While the output ready of a path stays high, the input ready of that path stays high, so the path carries one byte on every cycle.
- R9: tc_count gives the number of adjacent bit changes in the 10-bit frame formed by a 0 bit, then tc_data from bit 0 to bit 7, then a 0 bit. Examples: 0x65 gives 6, 0xFE gives 2, 0x00 gives 0 and 0x55 gives 8. The value is always even.
- R10: For each of the eight codes of R2, tc_count gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_in_valid | input | 1 | Host byte available for the encoder |
| enc_in_ready | output | 1 | Encoder can accept a byte |
| enc_in_data | input | 8 | Host byte to encode |
| enc_out_valid | output | 1 | Encoded byte available |
| enc_out_ready | input | 1 | Consumer takes the encoded byte |
| enc_out_data | output | 8 | Encoded byte |
| dec_in_valid | input | 1 | Received byte available for the decoder |
| dec_in_ready | output | 1 | Decoder can accept a byte |
| dec_in_data | input | 8 | Received byte to decode |
| dec_out_valid | output | 1 | Decoded byte available |
| dec_out_ready | input | 1 | Host takes the decoded byte |
| dec_out_data | output | 8 | Decoded byte |
| tc_data | input | 8 | Byte to measure |
| tc_count | output | 4 | Line transitions of the framed byte |

## Verification
The only state in the block is one valid flag and one data register per path. If either one is wrong, the error shows up at the ports on the cycle right after the edge where it was corrupted. A valid flag that is cleared by mistake loses a byte, and the scoreboard detects this as a missing or shifted item. A valid flag that is set by mistake, or data that changes during a stall, shows up as a duplicated item or as a failed hold check on the next sample. A wrong table entry shows up the first time that letter or code passes through.

// File: rtl/lt_codec_pkg.sv
package lt_codec_pkg;

  localparam int CHAR_W    = 8;
  localparam int NUM_CODES = 8;
  localparam int MARK_BIT  = CHAR_W - 1;

  // Letters ordered by how often they appear, most frequent first.
  function automatic logic [CHAR_W-1:0] plain_char(input int idx);
    case (idx)
      0:       plain_char = 8'h65; // e
      1:       plain_char = 8'h74; // t
      2:       plain_char = 8'h61; // a
      3:       plain_char = 8'h6F; // o
      4:       plain_char = 8'h69; // i
      5:       plain_char = 8'h6E; // n
      6:       plain_char = 8'h73; // s
      default: plain_char = 8'h72; // r
    endcase
  endfunction

  // Each code is a run of ones then a run of zeros, so a framed code has two edges.
  function automatic logic [CHAR_W-1:0] code_word(input int idx);
    case (idx)
      0:       code_word = 8'hFE;
      1:       code_word = 8'hFC;
      2:       code_word = 8'hF8;
      3:       code_word = 8'hF0;
      4:       code_word = 8'hE0;
      5:       code_word = 8'hC0;
      6:       code_word = 8'h80;
      default: code_word = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/lt_remap.sv
module lt_remap #(
  parameter int W      = 8,
  parameter bit DECODE = 1'b0
) (
  input  logic [W-1:0] key_i,
  output logic [W-1:0] val_o,
  output logic         hit_o
);
  import lt_codec_pkg::*;

  localparam int N = NUM_CODES;

  logic [N-1:0] match;
  logic [W-1:0] repl [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    if (DECODE) begin : g_dec
      assign match[i] = (key_i == W'(code_word(i)));
      assign repl[i]  = W'(plain_char(i));
    end else begin : g_enc
      assign match[i] = (key_i == W'(plain_char(i)));
      assign repl[i]  = W'(code_word(i));
    end
  end

  always_comb begin
    val_o = key_i;
    hit_o = |match;
    for (int i = 0; i < N; i++) begin
      if (match[i]) val_o = repl[i];
    end
  end

endmodule

// File: rtl/lt_stage.sv
module lt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (take) begin
      out_data <= in_data;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R6

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

endmodule

// File: rtl/lt_transition_count.sv
module lt_transition_count #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 2)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] count_o
);

  logic [W+1:0] frame;

  assign frame = {1'b0, data_i, 1'b0};

  always_comb begin
    count_o = '0;
    for (int k = 0; k < W + 1; k++) begin
      if (frame[k] != frame[k+1]) count_o = count_o + CW'(1);
    end
  end

  always_comb begin
    if (!$isunknown(data_i)) begin
      AST_TC_EVEN: assert (count_o[0] == 1'b0); // R9
    end
  end

endmodule

// File: rtl/lt_ascii_codec.sv
module lt_ascii_codec #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_in_valid,
  output logic          enc_in_ready,
  input  logic [W-1:0]  enc_in_data,
  output logic          enc_out_valid,
  input  logic          enc_out_ready,
  output logic [W-1:0]  enc_out_data,
  input  logic          dec_in_valid,
  output logic          dec_in_ready,
  input  logic [W-1:0]  dec_in_data,
  output logic          dec_out_valid,
  input  logic          dec_out_ready,
  output logic [W-1:0]  dec_out_data,
  input  logic [W-1:0]  tc_data,
  output logic [CW-1:0] tc_count
);

  localparam int MSB = W - 1;

  logic [W-1:0] enc_mapped, dec_mapped;
  logic         enc_hit, dec_hit;

  lt_remap #(.W(W), .DECODE(1'b0)) u_enc_map (
    .key_i (enc_in_data),
    .val_o (enc_mapped),
    .hit_o (enc_hit)
  );

  lt_remap #(.W(W), .DECODE(1'b1)) u_dec_map (
    .key_i (dec_in_data),
    .val_o (dec_mapped),
    .hit_o (dec_hit)
  );

  lt_stage #(.W(W)) u_enc_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (enc_in_valid),
    .in_ready  (enc_in_ready),
    .in_data   (enc_mapped),
    .out_valid (enc_out_valid),
    .out_ready (enc_out_ready),
    .out_data  (enc_out_data)
  );

  lt_stage #(.W(W)) u_dec_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_data   (dec_mapped),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_data  (dec_out_data)
  );

  lt_transition_count #(.W(W), .CW(CW)) u_tc (
    .data_i  (tc_data),
    .count_o (tc_count)
  );

  AST_ENC_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready && enc_hit |=> enc_out_data[MSB]); // R2

  AST_ENC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    enc_in_valid && enc_in_ready && !enc_hit |=> enc_out_data == $past(enc_in_data)); // R3

  AST_DEC_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_in_ready && dec_hit |=> !dec_out_data[MSB]); // R4

  AST_DEC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    dec_in_valid && dec_in_ready && !dec_hit |=> dec_out_data == $past(dec_in_data)); // R5

  AST_RESET_IDLE: assert property (@(posedge clk)
    !$past(rst_n) |-> !enc_out_valid && !dec_out_valid); // R1

endmodule

// File: tb/tb_lt_ascii_codec.sv
module tb_lt_ascii_codec;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_in_valid = 1'b0, enc_in_ready, enc_out_valid, enc_out_ready = 1'b1;
  logic dec_in_valid = 1'b0, dec_in_ready, dec_out_valid, dec_out_ready = 1'b1;
  logic [7:0] enc_in_data = '0, enc_out_data, dec_in_data = '0, dec_out_data;
  logic [7:0] tc_data = '0;
  logic [3:0] tc_count;

  int checks = 0, errors = 0;
  int enc_stalls = 0, dec_stalls = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] enc_q[$], dec_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lt_ascii_codec dut (
    .clk(clk), .rst_n(rst_n),
    .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_data(enc_in_data),
    .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_data(enc_out_data),
    .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_data(dec_in_data),
    .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_data(dec_out_data),
    .tc_data(tc_data), .tc_count(tc_count)
  );

  function automatic logic [7:0] ref_enc(input logic [7:0] b);
    case (b)
      8'h65: ref_enc = 8'hFE; 8'h74: ref_enc = 8'hFC; 8'h61: ref_enc = 8'hF8;
      8'h6F: ref_enc = 8'hF0; 8'h69: ref_enc = 8'hE0; 8'h6E: ref_enc = 8'hC0;
      8'h73: ref_enc = 8'h80; 8'h72: ref_enc = 8'hFF;
      default: ref_enc = b;
    endcase
  endfunction

  function automatic logic [7:0] ref_dec(input logic [7:0] b);
    case (b)
      8'hFE: ref_dec = 8'h65; 8'hFC: ref_dec = 8'h74; 8'hF8: ref_dec = 8'h61;
      8'hF0: ref_dec = 8'h6F; 8'hE0: ref_dec = 8'h69; 8'hC0: ref_dec = 8'h6E;
      8'h80: ref_dec = 8'h73; 8'hFF: ref_dec = 8'h72;
      default: ref_dec = b;
    endcase
  endfunction

  function automatic int ref_tc(input logic [7:0] b);
    logic [9:0] f;
    f = {1'b0, b, 1'b0};
    return $countones(f ^ (f >> 1));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_enc(input logic [7:0] b, input logic [7:0] exp);
    @(negedge clk);
    enc_in_valid = 1'b1;
    enc_in_data  = b;
    #1;
    while (!enc_in_ready) begin
      enc_stalls++;
      @(negedge clk);
      #1;
    end
    enc_q.push_back(exp);
    @(posedge clk);
    #1;
    enc_in_valid = 1'b0;
  endtask

  task automatic send_dec(input logic [7:0] b, input logic [7:0] exp);
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_data  = b;
    #1;
    while (!dec_in_ready) begin
      dec_stalls++;
      @(negedge clk);
      #1;
    end
    dec_q.push_back(exp);
    @(posedge clk);
    #1;
    dec_in_valid = 1'b0;
  endtask

  // Consumer ready pattern, driven at the falling edge.
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    enc_out_ready = bp_mode ? lfsr[0] : 1'b1;
    dec_out_ready = bp_mode ? lfsr[3] : 1'b1;
  end

  // Monitor: samples between edges, pops on each transfer the next edge completes.
  bit enc_prev_stall = 1'b0, dec_prev_stall = 1'b0;
  logic [7:0] enc_prev_data, dec_prev_data;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (enc_prev_stall) begin
        check("R7 enc hold valid", int'(enc_out_valid), 1);
        check("R7 enc hold data", int'(enc_out_data), int'(enc_prev_data));
      end
      if (dec_prev_stall) begin
        check("R7 dec hold valid", int'(dec_out_valid), 1);
        check("R7 dec hold data", int'(dec_out_data), int'(dec_prev_data));
      end
      if (enc_out_valid && enc_out_ready) begin
        if (enc_q.size() == 0) check("R7 enc extra byte", int'(enc_out_data), -1);
        else check("R2 R3 enc data", int'(enc_out_data), int'(enc_q.pop_front()));
      end
      if (dec_out_valid && dec_out_ready) begin
        if (dec_q.size() == 0) check("R7 dec extra byte", int'(dec_out_data), -1);
        else check("R4 R5 dec data", int'(dec_out_data), int'(dec_q.pop_front()));
      end
      enc_prev_stall = enc_out_valid && !enc_out_ready;
      dec_prev_stall = dec_out_valid && !dec_out_ready;
      enc_prev_data  = enc_out_data;
      dec_prev_data  = dec_out_data;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    check("R1 enc_out_valid in reset", int'(enc_out_valid), 0);
    check("R1 dec_out_valid in reset", int'(dec_out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R1 enc_out_valid after reset", int'(enc_out_valid), 0);
    check("R1 dec_out_valid after reset", int'(dec_out_valid), 0);
    check("R1 enc_in_ready after reset", int'(enc_in_ready), 1);
    check("R1 dec_in_ready after reset", int'(dec_in_ready), 1);

    // R6: one-cycle latency on a single byte
    send_enc(8'h65, 8'hFE);
    @(negedge clk);
    #3;
    check("R6 enc valid next cycle", int'(enc_out_valid), 1);
    check("R6 enc data next cycle", int'(enc_out_data), 8'hFE);
    send_dec(8'hFC, 8'h74);
    @(negedge clk);
    #3;
    check("R6 dec valid next cycle", int'(dec_out_valid), 1);
    check("R6 dec data next cycle", int'(dec_out_data), 8'h74);

    // R2 / R4 table, R3 / R5 pass-through, R8 full rate
    enc_stalls = 0;
    dec_stalls = 0;
    fork
      begin
        send_enc(8'h65, 8'hFE); send_enc(8'h74, 8'hFC); send_enc(8'h61, 8'hF8);
        send_enc(8'h6F, 8'hF0); send_enc(8'h69, 8'hE0); send_enc(8'h6E, 8'hC0);
        send_enc(8'h73, 8'h80); send_enc(8'h72, 8'hFF);
        send_enc(8'h62, 8'h62); send_enc(8'h7A, 8'h7A); send_enc(8'h00, 8'h00);
        send_enc(8'h7F, 8'h7F); send_enc(8'h80, 8'h80); send_enc(8'hFE, 8'hFE);
        send_enc(8'h45, 8'h45);
      end
      begin
        send_dec(8'hFE, 8'h65); send_dec(8'hFC, 8'h74); send_dec(8'hF8, 8'h61);
        send_dec(8'hF0, 8'h6F); send_dec(8'hE0, 8'h69); send_dec(8'hC0, 8'h6E);
        send_dec(8'h80, 8'h73); send_dec(8'hFF, 8'h72);
        send_dec(8'h81, 8'h81); send_dec(8'hFD, 8'hFD); send_dec(8'h41, 8'h41);
        send_dec(8'h65, 8'h65); send_dec(8'h00, 8'h00);
      end
    join
    check("R8 enc no stalls with ready high", enc_stalls, 0);
    check("R8 dec no stalls with ready high", dec_stalls, 0);

    // R7: random back-pressure over a byte sweep
    bp_mode = 1'b1;
    fork
      for (int i = 0; i < 256; i++) send_enc(8'(i * 37), ref_enc(8'(i * 37)));
      for (int i = 0; i < 256; i++) send_dec(8'(i * 53), ref_dec(8'(i * 53)));
    join
    bp_mode = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 enc queue drained", enc_q.size(), 0);
    check("R7 dec queue drained", dec_q.size(), 0);

    // R9 / R10: transition counter
    tc_data = 8'h65; #1; check("R9 tc of 0x65", int'(tc_count), 6);
    tc_data = 8'hFE; #1; check("R9 tc of 0xFE", int'(tc_count), 2);
    tc_data = 8'h00; #1; check("R9 tc of 0x00", int'(tc_count), 0);
    tc_data = 8'h55; #1; check("R9 tc of 0x55", int'(tc_count), 8);
    for (int i = 0; i < 256; i += 7) begin
      tc_data = 8'(i); #1;
      check("R9 tc sweep", int'(tc_count), ref_tc(8'(i)));
    end
    for (int i = 0; i < 8; i++) begin
      logic [7:0] code;
      case (i)
        0: code = 8'hFE; 1: code = 8'hFC; 2: code = 8'hF8; 3: code = 8'hF0;
        4: code = 8'hE0; 5: code = 8'hC0; 6: code = 8'h80; default: code = 8'hFF;
      endcase
      tc_data = code; #1;
      check("R10 code has two transitions", int'(tc_count), 2);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule